// File: doc/BRIEF.md
# Core Low-Power Sequencer

This block decides when the processor core sleeps and when it wakes. From the running state it can enter a light idle, where only the CPU clock stops, or a deep idle, where the peripheral clock stops as well. It can also enter one of three bus-hold states, which put the external bus drivers into high impedance. A single mode input selects whether the CPU halts during a hold or keeps executing from on-chip resources.

In light idle, any interrupt line wakes the core. In deep idle, the on-chip sources are frozen, so only an external interrupt pin can wake the core. That pin counts only once it has been sampled high on a run of consecutive clock edges. On each wake from idle, the block issues a one-cycle wake action. This action tells the fetch logic to take the interrupt vector when the global interrupt mask is clear, or to continue with the next instruction when the mask is set.

The block holds no architectural state of the core. The core's registers stay untouched while clocks are gated, and execution resumes where it stopped.

Top module: `core_sleep_seq`

## Requirements
- R1: After reset the block is in the running state: cpu_clk_en_o=1, per_clk_en_o=1, bus_hiz_o=0, wake_vector_o=0, wake_inline_o=0.
- R2: Light idle is entered at the first clock edge that samples idle_light_i high in the running state. In light idle the outputs are cpu_clk_en_o=0, per_clk_en_o=1, bus_hiz_o=0. Light idle ends at the first edge that samples any bit of onchip_irq_i or ext_irq_i high.
- R3: A wake from either idle depth raises exactly one of wake_vector_o and wake_inline_o for exactly one cycle, which is the first running cycle. wake_vector_o is raised when int_mask_i was 0 at the waking edge, and wake_inline_o when it was 1. No other event raises either output.
- R4: Deep idle is entered from the running state when idle_deep_i is sampled high. In deep idle the outputs are cpu_clk_en_o=0, per_clk_en_o=0, bus_hiz_o=0. Bits of onchip_irq_i have no effect while in deep idle.
- R5: Deep idle ends at the edge that samples the same ext_irq_i bit high for the WAKE_HOLD_CYCLES-th consecutive edge (5 by default). A low sample restarts that pin's count, so shorter runs never wake the core.
- R6: A hold request sampled in the running state with hold_mode_i=1 gives cpu_clk_en_o=0, per_clk_en_o=1, bus_hiz_o=1.
- R7: A hold request with hold_mode_i=0 gives cpu_clk_en_o=1, per_clk_en_o=1, bus_hiz_o=1. Once ext_access_i is sampled high during such a hold (including the entering edge), cpu_clk_en_o=0 and stays 0 until the hold ends, even if ext_access_i falls.
- R8: Any hold state returns to the running state (cpu_clk_en_o=1, bus_hiz_o=0) at the first edge that samples hold_req_i low, with no wake action.
- R9: When several requests are sampled together in the running state, hold wins over deep idle, and deep idle wins over light idle.
- R10: Requests are acted on only in the running state. A hold request during light idle and an idle command during hold leave the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| idle_light_i | input | 1 | Light idle command |
| idle_deep_i | input | 1 | Deep idle command |
| hold_req_i | input | 1 | External bus hold request |
| hold_mode_i | input | 1 | 1: halt CPU during hold; 0: keep executing |
| onchip_irq_i | input | N_ONCHIP | Pending on-chip interrupts |
| ext_irq_i | input | N_EXT | External interrupt pin levels |
| int_mask_i | input | 1 | Global interrupt mask |
| ext_access_i | input | 1 | Core needs an off-chip access |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| bus_hiz_o | output | 1 | External address/control drivers to high impedance |
| wake_vector_o | output | 1 | Wake pulse: take interrupt vector |
| wake_inline_o | output | 1 | Wake pulse: continue with next instruction |

## Verification
The assertions check several rules on every cycle:
- The wake pulses are mutually exclusive and appear only right after an idle state.
- A qualified pin always has a high sample behind it.
- Deep idle persists while no pin is qualified.
- A stalled hold persists while the request stays high.
- Dropping the request always releases the bus without a wake action.

Only the bench scenarios can show the exact output codes of each state, the precise edge count that ends deep idle for each pin and run length, the mask-dependent choice of wake action, the priority among simultaneous requests, and the fact that requests are ignored outside the running state.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
  typedef enum logic [2:0] {
    ST_RUN       = 3'd0,
    ST_NAP       = 3'd1,
    ST_DEEP      = 3'd2,
    ST_HOLD_HALT = 3'd3,
    ST_HOLD_LIVE = 3'd4,
    ST_HOLD_WAIT = 3'd5
  } slp_state_e;

  typedef struct packed {
    logic cpu_en;
    logic per_en;
    logic hiz;
  } slp_ctl_t;
endpackage

// File: rtl/slp_pin_qual.sv
module slp_pin_qual #(
  parameter int QUAL_CYCLES = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic qual_o
);
  localparam int CW = (QUAL_CYCLES > 1) ? $clog2(QUAL_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(QUAL_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  // counts earlier consecutive high samples, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!pin_i)         cnt_q <= '0;
    else if (cnt_q < CNT_TOP) cnt_q <= cnt_q + 1'b1;
  end

  assign qual_o = pin_i && (cnt_q >= CNT_TOP);

  generate
    if (QUAL_CYCLES > 1) begin : g_chk
      // R5
      qual_history_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        qual_o |-> $past(pin_i));
    end
  endgenerate
endmodule

// File: rtl/slp_wake_src.sv
module slp_wake_src #(
  parameter int N_ONCHIP    = 3,
  parameter int N_EXT       = 2,
  parameter int QUAL_CYCLES = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_ONCHIP-1:0] onchip_irq_i,
  input  logic [N_EXT-1:0]    ext_irq_i,
  output logic                any_irq_o,
  output logic                deep_wake_o
);
  logic [N_EXT-1:0] qual;

  generate
    for (genvar g = 0; g < N_EXT; g++) begin : g_pin
      slp_pin_qual #(.QUAL_CYCLES(QUAL_CYCLES)) i_qual (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (ext_irq_i[g]),
        .qual_o (qual[g])
      );
    end
  endgenerate

  assign any_irq_o   = (|onchip_irq_i) | (|ext_irq_i);
  assign deep_wake_o = |qual;
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
  import sleep_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idle_light_i,
  input  logic       idle_deep_i,
  input  logic       hold_req_i,
  input  logic       hold_mode_i,
  input  logic       ext_access_i,
  input  logic       int_mask_i,
  input  logic       any_irq_i,
  input  logic       deep_wake_i,
  output slp_state_e state_o,
  output logic       wake_vector_o,
  output logic       wake_inline_o
);
  slp_state_e st_q, st_d;
  logic wake_d, vec_q, inl_q;

  always_comb begin
    st_d   = st_q;
    wake_d = 1'b0;
    case (st_q)
      ST_RUN: begin
        if (hold_req_i)
          st_d = hold_mode_i ? ST_HOLD_HALT :
                 (ext_access_i ? ST_HOLD_WAIT : ST_HOLD_LIVE);
        else if (idle_deep_i)  st_d = ST_DEEP;
        else if (idle_light_i) st_d = ST_NAP;
      end
      ST_NAP:  if (any_irq_i)   begin st_d = ST_RUN; wake_d = 1'b1; end
      ST_DEEP: if (deep_wake_i) begin st_d = ST_RUN; wake_d = 1'b1; end
      ST_HOLD_HALT: if (!hold_req_i) st_d = ST_RUN;
      ST_HOLD_LIVE: begin
        if (!hold_req_i)       st_d = ST_RUN;
        else if (ext_access_i) st_d = ST_HOLD_WAIT;
      end
      ST_HOLD_WAIT: if (!hold_req_i) st_d = ST_RUN;
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_RUN;
      vec_q <= 1'b0;
      inl_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      vec_q <= wake_d & ~int_mask_i;
      inl_q <= wake_d & int_mask_i;
    end
  end

  assign state_o       = st_q;
  assign wake_vector_o = vec_q;
  assign wake_inline_o = inl_q;

  // R3
  wake_after_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_q || inl_q) |-> ($past(st_q) == ST_NAP || $past(st_q) == ST_DEEP));
  // R3
  wake_one_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({vec_q, inl_q}));
  // R7
  stall_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HOLD_WAIT && hold_req_i) |=> st_q == ST_HOLD_WAIT);
endmodule

// File: rtl/slp_out_dec.sv
module slp_out_dec
  import sleep_pkg::*;
(
  input  slp_state_e state_i,
  output slp_ctl_t   ctl_o
);
  always_comb begin
    case (state_i)
      ST_RUN:       ctl_o = '{cpu_en: 1'b1, per_en: 1'b1, hiz: 1'b0};
      ST_NAP:       ctl_o = '{cpu_en: 1'b0, per_en: 1'b1, hiz: 1'b0};
      ST_DEEP:      ctl_o = '{cpu_en: 1'b0, per_en: 1'b0, hiz: 1'b0};
      ST_HOLD_HALT: ctl_o = '{cpu_en: 1'b0, per_en: 1'b1, hiz: 1'b1};
      ST_HOLD_LIVE: ctl_o = '{cpu_en: 1'b1, per_en: 1'b1, hiz: 1'b1};
      ST_HOLD_WAIT: ctl_o = '{cpu_en: 1'b0, per_en: 1'b1, hiz: 1'b1};
      default:      ctl_o = '{cpu_en: 1'b1, per_en: 1'b1, hiz: 1'b0};
    endcase
  end
endmodule

// File: rtl/core_sleep_seq.sv
module core_sleep_seq
  import sleep_pkg::*;
#(
  parameter int N_ONCHIP         = 3,
  parameter int N_EXT            = 2,
  parameter int WAKE_HOLD_CYCLES = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                idle_light_i,
  input  logic                idle_deep_i,
  input  logic                hold_req_i,
  input  logic                hold_mode_i,
  input  logic [N_ONCHIP-1:0] onchip_irq_i,
  input  logic [N_EXT-1:0]    ext_irq_i,
  input  logic                int_mask_i,
  input  logic                ext_access_i,
  output logic                cpu_clk_en_o,
  output logic                per_clk_en_o,
  output logic                bus_hiz_o,
  output logic                wake_vector_o,
  output logic                wake_inline_o
);
  logic       any_irq, deep_wake;
  slp_state_e state;
  slp_ctl_t   ctl;

  slp_wake_src #(
    .N_ONCHIP(N_ONCHIP), .N_EXT(N_EXT), .QUAL_CYCLES(WAKE_HOLD_CYCLES)
  ) i_src (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .onchip_irq_i (onchip_irq_i),
    .ext_irq_i    (ext_irq_i),
    .any_irq_o    (any_irq),
    .deep_wake_o  (deep_wake)
  );

  slp_fsm i_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .idle_light_i  (idle_light_i),
    .idle_deep_i   (idle_deep_i),
    .hold_req_i    (hold_req_i),
    .hold_mode_i   (hold_mode_i),
    .ext_access_i  (ext_access_i),
    .int_mask_i    (int_mask_i),
    .any_irq_i     (any_irq),
    .deep_wake_i   (deep_wake),
    .state_o       (state),
    .wake_vector_o (wake_vector_o),
    .wake_inline_o (wake_inline_o)
  );

  slp_out_dec i_dec (
    .state_i (state),
    .ctl_o   (ctl)
  );

  assign cpu_clk_en_o = ctl.cpu_en;
  assign per_clk_en_o = ctl.per_en;
  assign bus_hiz_o    = ctl.hiz;

  // R4
  deep_stays_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!per_clk_en_o && !deep_wake) |=> !per_clk_en_o);
  // R8
  hold_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_hiz_o && !hold_req_i) |=>
      (!bus_hiz_o && cpu_clk_en_o && !wake_vector_o && !wake_inline_o));
  // R2
  nap_no_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_NAP && !any_irq) |=> (state == ST_NAP));
endmodule

// File: tb/test_core_sleep_seq.sv
`timescale 1ns/1ps
module test_core_sleep_seq;
  localparam int NO = 3, NE = 2, QH = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic idle_l = 0, idle_d = 0, hold = 0, hmode = 0, mask = 0, xacc = 0;
  logic [NO-1:0] oirq = '0;
  logic [NE-1:0] eirq = '0;
  logic cpu_en, per_en, hiz, wv, wi;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  core_sleep_seq #(.N_ONCHIP(NO), .N_EXT(NE), .WAKE_HOLD_CYCLES(QH)) i_core_sleep_seq (
    .clk_i(clk), .rst_ni(rst_n), .idle_light_i(idle_l), .idle_deep_i(idle_d),
    .hold_req_i(hold), .hold_mode_i(hmode), .onchip_irq_i(oirq), .ext_irq_i(eirq),
    .int_mask_i(mask), .ext_access_i(xacc), .cpu_clk_en_o(cpu_en),
    .per_clk_en_o(per_en), .bus_hiz_o(hiz), .wake_vector_o(wv), .wake_inline_o(wi)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [4:0] exp);
    logic [4:0] act;
    act = {cpu_en, per_en, hiz, wv, wi};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // {cpu,per,hiz,wv,wi}
  localparam logic [4:0] O_RUN = 5'b11000, O_NAP = 5'b01000, O_DEEP = 5'b00000,
                         O_HALT = 5'b01100, O_LIVE = 5'b11100;

  function automatic logic [4:0] woke(input logic m);
    return m ? 5'b11001 : 5'b11010;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #5; chk("R1 reset", O_RUN);
    rst_n = 1'b1;
    tick(); chk("R1 after release", O_RUN);

    // R2/R3: light idle, each line as wake source, both mask values
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < NO + NE; s++) begin
        mask = m[0];
        idle_l = 1; tick(); idle_l = 0;
        tick(); chk("R2 nap entry", O_NAP);
        if (s < NO) oirq[s] = 1'b1; else eirq[s-NO] = 1'b1;
        tick(); chk("R3 nap wake action", woke(mask));
        oirq = '0; eirq = '0;
        tick(); chk("R3 pulse one cycle", O_RUN);
      end
    end

    // R4/R5: deep idle, run lengths per pin, both masks
    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p < NE; p++) begin
        mask = m[0];
        idle_d = 1; tick(); idle_d = 0;
        chk("R4 deep entry", O_DEEP);
        oirq = '1; tick(); tick(); chk("R4 onchip ignored", O_DEEP);
        oirq = '0;
        for (int len = 1; len < QH; len++) begin
          eirq[p] = 1'b1;
          for (int k = 0; k < len; k++) tick();
          eirq[p] = 1'b0; tick();
          chk("R5 short run no wake", O_DEEP);
        end
        eirq[p] = 1'b1;
        for (int k = 1; k < QH; k++) begin
          tick(); chk("R5 still deep", O_DEEP);
        end
        tick(); chk("R5 wake at count", woke(mask));
        eirq[p] = 1'b0;
        tick(); chk("R3 deep pulse ends", O_RUN);
      end
    end

    // R6/R8: hold halting
    hmode = 1; hold = 1; tick(); chk("R6 hold halt", O_HALT);
    xacc = 1; tick(); chk("R6 stays", O_HALT); xacc = 0;
    hold = 0; tick(); chk("R8 release halt", O_RUN);

    // R7/R8: hold live, then stall
    hmode = 0; hold = 1; tick(); chk("R7 hold live", O_LIVE);
    xacc = 1; tick(); chk("R7 stall", O_HALT);
    xacc = 0; tick(); chk("R7 stall persists", O_HALT);
    hold = 0; tick(); chk("R8 release stall", O_RUN);
    hold = 1; xacc = 1; tick(); chk("R7 stall on entry", O_HALT);
    xacc = 0; hold = 0; tick(); chk("R8 release", O_RUN);

    // R9 priority
    hold = 1; idle_d = 1; idle_l = 1; hmode = 1;
    tick(); chk("R9 hold first", O_HALT);
    hold = 0; tick(); chk("R9 back run", O_RUN);
    idle_l = 1; tick(); idle_d = 0; idle_l = 0;
    chk("R9 deep over light", O_DEEP);
    eirq[0] = 1; for (int k = 0; k < QH; k++) tick(); eirq[0] = 0;
    chk("R5 wake", woke(mask));

    // R10 ignored requests
    idle_l = 1; tick(); idle_l = 0;
    hold = 1; tick(); tick(); chk("R10 hold ignored in nap", O_NAP);
    hold = 0; oirq[0] = 1; tick(); oirq = '0; chk("R2 wake", woke(mask));
    hmode = 0; hold = 1; tick(); chk("R7 live", O_LIVE);
    idle_d = 1; idle_l = 1; tick(); tick(); chk("R10 idle ignored in hold", O_LIVE);
    idle_d = 0; idle_l = 0; hold = 0; tick(); chk("R8 release", O_RUN);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule